// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA request lines is served next. Each channel drives one request line. When the arbiter is idle and at least one line is raised, it picks one requester, registers a one-hot grant, raises a busy flag and reports the binary number of the chosen channel. The grant then stays locked to that channel, whatever the other lines do, until the transfer engine pulses the service-complete input. The arbiter returns to idle for one cycle and then arbitrates again.

A control input selects one of two orderings. In fixed ordering the lowest-numbered channel that is requesting wins. In rotating ordering the search starts at the channel just above the one served last, wrapping from 3 to 0. The channel that was just served therefore falls to the bottom, and a waiting channel is reached within three services to other channels. The rotation pointer moves only when a service completes, and it moves in both orderings. The ordering bit is read only at the moment of arbitration, so a change during a service takes effect at the next choice.

Top module: `dma_prio_arb`

## Requirements
- R1: With `rotate_i`=0, arbitration grants the lowest-numbered channel whose request bit is 1 (bit i of `req_i` is channel i).
- R2: With `rotate_i`=1, arbitration checks channels in the order p, p+1, ... wrapping modulo 4, where p is one more (mod 4) than the channel whose service completed last, and grants the first one that is requesting.
- R3: While `busy_o`=1 and `done_i`=0, `grant_o` and `grant_idx_o` do not change, whatever `req_i` and `rotate_i` do.
- R4: A `done_i`=1 cycle while busy clears `busy_o`, `grant_o` and `grant_idx_o` to 0 one clock later. The next grant comes no earlier than the clock after that.
- R5: With all four requests held and `rotate_i`=1, four consecutive services go to four different channels.
- R6: After reset `grant_o`=0, `busy_o`=0 and `grant_idx_o`=0, and the rotation start p is channel 0.
- R7: The rotation start p is updated on every completed service in both orderings, and at no other time. A rotating arbitration that follows fixed-order services therefore starts after the last channel served.
- R8: A change of `rotate_i` during a service has no effect on the current grant. The next arbitration uses the new value.
- R9: `done_i` while idle has no effect: `busy_o` stays 0 and the rotation start does not move.
- R10: When idle with any request bit set, one clock later `busy_o`=1, `grant_o` is one-hot on a requesting channel, and `grant_idx_o` is that channel's binary number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 4 | Request lines, bit i is channel i |
| rotate_i | input | 1 | 1 selects rotating ordering, 0 selects fixed ordering |
| done_i | input | 1 | One-cycle pulse marking the end of the current service |
| grant_o | output | 4 | One-hot grant, all zero when idle |
| busy_o | output | 1 | A service is in progress |
| grant_idx_o | output | 2 | Binary number of the granted channel, 0 when idle |

## Verification
The assertions assume that `done_i` is a single-cycle pulse. They also assume that requests, the ordering bit and `done_i` are sampled at the rising edge, so they must be settled before it. The stimulus changes inputs only on the falling clock edge and raises `done_i` for exactly one cycle. It pulses `done_i` while idle only in the test of R9. The sweep visits every nonzero request pattern in both orderings from every rotation start, and it reaches each start by first serving one chosen channel alone.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_FIXED  = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NCH   = 4,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   req_i,
  input  logic [IDX_W-1:0] base_i,
  output logic             hit_o,
  output logic [NCH-1:0]   pick_oh_o,
  output logic [IDX_W-1:0] pick_idx_o
);
  // search upward from base_i, wrapping modulo NCH
  always_comb begin
    hit_o      = 1'b0;
    pick_oh_o  = '0;
    pick_idx_o = '0;
    for (int k = 0; k < NCH; k++) begin
      logic [IDX_W-1:0] cand;
      cand = IDX_W'((int'(base_i) + k) % NCH);
      if (!hit_o && req_i[cand]) begin
        hit_o           = 1'b1;
        pick_idx_o      = cand;
        pick_oh_o[cand] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_ptr.sv
module dma_arb_ptr #(
  parameter int NCH   = 4,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [IDX_W-1:0] served_idx_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  assign ptr_en = busy_i && done_i;

  always_comb begin
    if (served_idx_i == IDX_W'(NCH - 1)) ptr_d = '0;
    else                                  ptr_d = served_idx_i + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_i && done_i) |=> $stable(ptr_q));
  p_ptr_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && done_i) |=> (ptr_q != $past(served_idx_i)));
endmodule

// File: rtl/dma_arb_gnt.sv
module dma_arb_gnt #(
  parameter int NCH   = 4,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic [NCH-1:0]   pick_oh_i,
  input  logic [IDX_W-1:0] pick_idx_i,
  input  logic             done_i,
  output logic [NCH-1:0]   gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  logic [NCH-1:0]   gnt_q, gnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;
  logic             ld_en;

  assign ld_en = busy_q ? done_i : hit_i;

  always_comb begin
    if (busy_q) begin
      gnt_d  = '0;
      idx_d  = '0;
      busy_d = 1'b0;
    end else begin
      gnt_d  = pick_oh_i;
      idx_d  = pick_idx_i;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (ld_en) begin
      gnt_q  <= gnt_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign gnt_o  = gnt_q;
  assign idx_o  = idx_q;
  assign busy_o = busy_q;

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ($onehot(gnt_q) && gnt_q[idx_q]));
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (gnt_q == '0 && idx_q == '0));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i) |=> (busy_q && $stable(gnt_q) && $stable(idx_q)));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i) |=> !busy_q);
  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !hit_i && done_i) |=> !busy_q);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH   = 4,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req_i,
  input  logic             rotate_i,
  input  logic             done_i,
  output logic [NCH-1:0]   grant_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] grant_idx_o
);
  import dma_arb_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  arb_mode_e        mode;
  logic [IDX_W-1:0] ptr, base;
  logic             hit;
  logic [NCH-1:0]   pick_oh;
  logic [IDX_W-1:0] pick_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode = rotate_i ? ARB_ROTATE : ARB_FIXED;
  assign base = (mode == ARB_ROTATE) ? ptr : '0;

  dma_arb_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
    .req_i      (req_i),
    .base_i     (base),
    .hit_o      (hit),
    .pick_oh_o  (pick_oh),
    .pick_idx_o (pick_idx)
  );

  dma_arb_gnt #(.NCH(NCH), .IDX_W(IDX_W)) u_gnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hit_i      (hit),
    .pick_oh_i  (pick_oh),
    .pick_idx_i (pick_idx),
    .done_i     (done_i),
    .gnt_o      (grant_o),
    .idx_o      (grant_idx_o),
    .busy_o     (busy_o)
  );

  dma_arb_ptr #(.NCH(NCH), .IDX_W(IDX_W)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .busy_i       (busy_o),
    .done_i       (done_i),
    .served_idx_i (grant_idx_o),
    .ptr_o        (ptr)
  );

  p_grant_req_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && req_i != '0) |=> (busy_o && (grant_o & ~$past(req_i)) == '0));
  p_fixed_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && !rotate_i && req_i != '0) |=>
      (grant_o == ($past(req_i) & (~$past(req_i) + 1'b1))));
  p_rot_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && rotate_i && req_i[ptr]) |=> (grant_idx_o == $past(ptr)));
endmodule

// File: tb/dma_prio_arb_test.sv
`timescale 1ns/1ps
module dma_prio_arb_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req;
  logic       rotate;
  logic       done;
  logic [3:0] grant;
  logic       busy;
  logic [1:0] gidx;

  int n_chk = 0;
  int n_bad = 0;
  int mptr  = 0;
  bit fin   = 1'b0;

  always #2.5 clk = ~clk;

  dma_prio_arb uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rotate_i(rotate), .done_i(done),
    .grant_o(grant), .busy_o(busy), .grant_idx_o(gidx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [3:0] r, input bit rot, input int p);
    int b = rot ? p : 0;
    for (int k = 0; k < 4; k++) if (r[(b + k) % 4]) return (b + k) % 4;
    return -1;
  endfunction

  // called at a falling edge while idle; leaves at a falling edge, idle
  task automatic serve(input logic [3:0] r, input bit rot, input string tag);
    int e = pick(r, rot, mptr);
    req = r; rotate = rot;
    @(negedge clk);
    chk({tag, " busy"}, int'(busy), 1);
    chk({tag, " idx"}, int'(gidx), e);
    chk({tag, " onehot R10"}, int'(grant), 1 << e);
    req = 4'h0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R4 busy clear", int'(busy), 0);
    chk("R4 grant clear", int'(grant), 0);
    mptr = (e + 1) % 4;
  endtask

  initial begin
    int seen;
    rst_n = 1'b0; req = 4'h0; rotate = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 grant", int'(grant), 0);
    chk("R6 busy", int'(busy), 0);
    chk("R6 idx", int'(gidx), 0);

    // R9: done while idle is ignored
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R9 busy", int'(busy), 0);
    serve(4'hF, 1'b1, "R6 R9 start at 0");

    // R1 / R2 sweep from every rotation start
    for (int rot = 0; rot < 2; rot++)
      for (int c = 0; c < 4; c++)
        for (int pat = 1; pat < 16; pat++) begin
          serve(4'(1 << c), 1'b0, "R1 setup");
          serve(4'(pat), rot[0], rot ? "R2 sweep" : "R1 sweep");
        end

    // R7: fixed-order service moves the rotation start
    serve(4'b0100, 1'b0, "R7 fixed");
    serve(4'hF, 1'b1, "R7 rotate after fixed");

    // R3: grant locked while busy
    req = 4'b1000; rotate = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      req = 4'(i * 5 + 1); rotate = i[0];
      @(negedge clk);
      chk("R3 grant held", int'(grant), 8);
      chk("R3 idx held", int'(gidx), 3);
    end
    req = 4'h0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    mptr = 0;

    // R8: mode change mid-service applies at next arbitration
    req = 4'b0010; rotate = 1'b0;
    @(negedge clk);
    rotate = 1'b1;
    @(negedge clk);
    chk("R8 current grant", int'(gidx), 1);
    req = 4'h0; done = 1'b1;
    @(negedge clk);
    done = 1'b0; mptr = 2;
    serve(4'hF, 1'b1, "R8 now rotating");
    req = 4'b1000; rotate = 1'b1;
    @(negedge clk);
    rotate = 1'b0;
    @(negedge clk);
    req = 4'h0; done = 1'b1;
    @(negedge clk);
    done = 1'b0; mptr = 0;
    serve(4'hF, 1'b0, "R8 now fixed");

    // R5: all requests held, rotating, four distinct services
    seen = 0;
    req = 4'hF; rotate = 1'b1;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R5 busy", int'(busy), 1);
      chk("R5 order", int'(gidx), (mptr + n) % 4);
      seen = seen | (1 << gidx);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
    end
    chk("R5 all served", seen, 15);
    req = 4'h0;
    @(negedge clk);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule